// File: doc/BRIEF.md
# Programmable-Tap Self-Synchronizing Scrambler Pair

This block whitens a serial baseband bit stream before spreading and restores it after despreading. It has a transmit scrambler and a receive descrambler. Each is built on a seven-stage delay line. A single configuration byte selects which stages feed the modulo-2 feedback sum. The same byte programs both directions, so a link needs only one register to agree on its polynomial.

On the transmit side, each valid input bit is XORed with the parity of the selected stages. The result is the output bit, and that output bit is pushed into the delay line. On the receive side, the received bit itself is pushed into the delay line. Because of this, any difference in starting state between the two ends is flushed out after as many valid bits as there are stages: the descrambler locks on without any sync word. The top bit of the configuration byte inverts a copy of the scrambled stream that is offered as the quadrature output.

Top module: `tap_scrambler_pair`

## Requirements
- R1: A synchronous reset (rst high at a clock edge) clears both delay lines, the tap mask and the invert bit, and drives tx_valid_out, rx_valid_out, tx_i_out, tx_q_out and rx_bit_out to 0.
- R2: With a tap mask of all zeros, each valid bit comes out unchanged on its side one cycle later.
- R3: For each clock edge with tx_valid_in high, the edge sets tx_i_out to tx_bit_in XOR the parity of the delay-line stages selected by the mask. tx_valid_out is tx_valid_in delayed by one cycle.
- R4: Mask bit k (k = 0..6) selects the stage holding the bit from k+1 valid bits earlier, and each valid bit shifts the line by one. The mask 7'b1001000 therefore realises 1 + x^-4 + x^-7.
- R5: For each clock edge with rx_valid_in high, the edge sets rx_bit_out to rx_bit_in XOR the parity of the selected receive stages, and pushes rx_bit_in into the receive line. rx_valid_out is rx_valid_in delayed by one cycle.
- R6: When both lines start from the same state and the same mask is used, feeding the transmit output to the receive input reproduces the original bits.
- R7: With the receive line in any state, the receive output equals the original data from the eighth valid bit of a scrambled stream onward.
- R8: A cycle without its valid strobe neither shifts that side's delay line nor changes that side's data output.
- R9: tx_q_out equals tx_i_out when configuration bit 7 is 0, and equals its complement when bit 7 is 1.
- R10: A configuration write (cfg_we high, bits 6..0 = mask, bit 7 = invert) takes effect for data bits clocked on later edges. A bit clocked on the same edge as the write still uses the previous mask.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous reset, active high |
| cfg_we | input | 1 | Configuration write strobe |
| cfg_data | input | 8 | Bits 6..0 tap mask, bit 7 quadrature invert |
| tx_valid_in | input | 1 | Transmit input bit valid |
| tx_bit_in | input | 1 | Transmit plain bit |
| tx_valid_out | output | 1 | Transmit output valid |
| tx_i_out | output | 1 | Scrambled bit |
| tx_q_out | output | 1 | Scrambled bit, optionally inverted |
| rx_valid_in | input | 1 | Receive input bit valid |
| rx_bit_in | input | 1 | Received scrambled bit |
| rx_valid_out | output | 1 | Receive output valid |
| rx_bit_out | output | 1 | Descrambled bit |

## Verification
Every data result appears on the edge that samples its valid strobe. The bench therefore sees it one clock later: it drives inputs on the falling edge and compares at the following falling edge. A configuration write changes only bits clocked on later edges, and the bench's model applies the new mask after it has computed the output for that edge. Recovery of the original data after an unknown receive state is due from the eighth valid bit onward, so the lock check skips the first seven bits of that stream. The quadrature output is checked in the same cycle as tx_i_out.

// File: rtl/scr_pkg.sv
package scr_pkg;
   typedef enum logic { SCR_DIR_TX = 1'b0, SCR_DIR_RX = 1'b1 } scr_dir_e;

   function automatic logic tap_parity(input logic [31:0] line, input logic [31:0] mask);
      tap_parity = ^(line & mask);
   endfunction
endpackage

// File: rtl/scr_tap_cfg.sv
module scr_tap_cfg #(
   parameter int STAGES = 7,
   localparam int CFG_W = STAGES + 1
) (
   input  logic              clk,
   input  logic              rst,
   input  logic              we,
   input  logic [CFG_W-1:0]  wdata,
   output logic [STAGES-1:0] taps,
   output logic              q_inv
);
   initial begin
      if (STAGES < 2 || STAGES > 31) $error("scr_tap_cfg: STAGES out of range");
   end

   always_ff @(posedge clk) begin
      if (rst) begin
         taps  <= '0;
         q_inv <= 1'b0;
      end else if (we) begin
         taps  <= wdata[STAGES-1:0];
         q_inv <= wdata[STAGES];
      end
   end
endmodule

// File: rtl/scr_lane.sv
module scr_lane
   import scr_pkg::*;
#(
   parameter int       STAGES = 7,
   parameter scr_dir_e DIR    = SCR_DIR_TX
) (
   input  logic              clk,
   input  logic              rst,
   input  logic [STAGES-1:0] taps,
   input  logic              vld_in,
   input  logic              din,
   output logic              vld_out,
   output logic              dout
);
   logic [STAGES-1:0] line_q;
   logic              fb;
   logic              nxt_bit;
   logic              push_bit;

   initial begin
      if (STAGES < 2 || STAGES > 31) $error("scr_lane: STAGES out of range");
   end

   assign fb      = tap_parity(32'(line_q), 32'(taps));
   assign nxt_bit = din ^ fb;

   generate
      if (DIR == SCR_DIR_TX) begin : g_scramble
         assign push_bit = nxt_bit;
      end else begin : g_descramble
         assign push_bit = din;
      end
   endgenerate

   always_ff @(posedge clk) begin
      if (rst) begin
         line_q  <= '0;
         dout    <= 1'b0;
         vld_out <= 1'b0;
      end else begin
         vld_out <= vld_in;
         if (vld_in) begin
            line_q <= {line_q[STAGES-2:0], push_bit};
            dout   <= nxt_bit;
         end
      end
   end
endmodule

// File: rtl/tap_scrambler_pair.sv
module tap_scrambler_pair
   import scr_pkg::*;
#(
   parameter int STAGES = 7,
   localparam int CFG_W = STAGES + 1
) (
   input  logic             clk,
   input  logic             rst,
   input  logic             cfg_we,
   input  logic [CFG_W-1:0] cfg_data,
   input  logic             tx_valid_in,
   input  logic             tx_bit_in,
   output logic             tx_valid_out,
   output logic             tx_i_out,
   output logic             tx_q_out,
   input  logic             rx_valid_in,
   input  logic             rx_bit_in,
   output logic             rx_valid_out,
   output logic             rx_bit_out
);
   logic [STAGES-1:0] taps;
   logic              q_inv;

   scr_tap_cfg #(.STAGES(STAGES)) u_cfg (
      .clk(clk), .rst(rst), .we(cfg_we), .wdata(cfg_data),
      .taps(taps), .q_inv(q_inv)
   );

   scr_lane #(.STAGES(STAGES), .DIR(SCR_DIR_TX)) u_tx (
      .clk(clk), .rst(rst), .taps(taps),
      .vld_in(tx_valid_in), .din(tx_bit_in),
      .vld_out(tx_valid_out), .dout(tx_i_out)
   );

   scr_lane #(.STAGES(STAGES), .DIR(SCR_DIR_RX)) u_rx (
      .clk(clk), .rst(rst), .taps(taps),
      .vld_in(rx_valid_in), .din(rx_bit_in),
      .vld_out(rx_valid_out), .dout(rx_bit_out)
   );

   assign tx_q_out = tx_i_out ^ q_inv;
endmodule

// File: rtl/scr_pair_chk.sv
module scr_pair_chk #(
   parameter int STAGES = 7,
   localparam int CFG_W = STAGES + 1
) (
   input logic             clk,
   input logic             rst,
   input logic             cfg_we,
   input logic [CFG_W-1:0] cfg_data,
   input logic             tx_valid_in,
   input logic             tx_bit_in,
   input logic             tx_valid_out,
   input logic             tx_i_out,
   input logic             tx_q_out,
   input logic             rx_valid_in,
   input logic             rx_bit_in,
   input logic             rx_valid_out,
   input logic             rx_bit_out
);
   logic [STAGES-1:0] mask_shadow;
   logic              inv_shadow;

   always_ff @(posedge clk) begin
      if (rst) begin
         mask_shadow <= '0;
         inv_shadow  <= 1'b0;
      end else if (cfg_we) begin
         mask_shadow <= cfg_data[STAGES-1:0];
         inv_shadow  <= cfg_data[STAGES];
      end
   end

   p_reset_r1: assert property (@(posedge clk)
      rst |=> (!tx_valid_out && !rx_valid_out && !tx_i_out && !rx_bit_out));

   p_tx_valid_r3: assert property (@(posedge clk) disable iff (rst)
      tx_valid_in |=> tx_valid_out);

   p_tx_novalid_r3: assert property (@(posedge clk) disable iff (rst)
      !tx_valid_in |=> !tx_valid_out);

   p_rx_valid_r5: assert property (@(posedge clk) disable iff (rst)
      rx_valid_in |=> rx_valid_out);

   p_tx_pass_r2: assert property (@(posedge clk) disable iff (rst)
      (tx_valid_in && mask_shadow == '0) |=> (tx_i_out == $past(tx_bit_in)));

   p_rx_pass_r2: assert property (@(posedge clk) disable iff (rst)
      (rx_valid_in && mask_shadow == '0) |=> (rx_bit_out == $past(rx_bit_in)));

   p_rx_hold_r8: assert property (@(posedge clk) disable iff (rst)
      !rx_valid_in |=> $stable(rx_bit_out));

   p_tx_hold_r8: assert property (@(posedge clk) disable iff (rst)
      !tx_valid_in |=> $stable(tx_i_out));

   always_comb begin
      if (!rst) begin
         p_qinv_r9: assert (tx_q_out == (tx_i_out ^ inv_shadow));
      end
   end
endmodule

bind tap_scrambler_pair scr_pair_chk #(.STAGES(STAGES)) u_chk (
   .clk(clk), .rst(rst), .cfg_we(cfg_we), .cfg_data(cfg_data),
   .tx_valid_in(tx_valid_in), .tx_bit_in(tx_bit_in),
   .tx_valid_out(tx_valid_out), .tx_i_out(tx_i_out), .tx_q_out(tx_q_out),
   .rx_valid_in(rx_valid_in), .rx_bit_in(rx_bit_in),
   .rx_valid_out(rx_valid_out), .rx_bit_out(rx_bit_out)
);

// File: tb/sim_tap_scrambler_pair.sv
`timescale 1ns/1ps
module sim_tap_scrambler_pair;
   logic       clk = 1'b0;
   logic       rst = 1'b1;
   logic       cfg_we = 1'b0;
   logic [7:0] cfg_data = '0;
   logic       tx_valid_in = 1'b0, tx_bit_in = 1'b0;
   logic       rx_valid_in = 1'b0, rx_bit_in = 1'b0;
   logic       tx_valid_out, tx_i_out, tx_q_out, rx_valid_out, rx_bit_out;

   int checks = 0;
   int errors = 0;
   bit done = 1'b0;
   string cur_req = "R1";

   always #2.5 clk = ~clk;

   tap_scrambler_pair u0 (
      .clk(clk), .rst(rst), .cfg_we(cfg_we), .cfg_data(cfg_data),
      .tx_valid_in(tx_valid_in), .tx_bit_in(tx_bit_in),
      .tx_valid_out(tx_valid_out), .tx_i_out(tx_i_out), .tx_q_out(tx_q_out),
      .rx_valid_in(rx_valid_in), .rx_bit_in(rx_bit_in),
      .rx_valid_out(rx_valid_out), .rx_bit_out(rx_bit_out)
   );

   // behavioural reference: histories as queues, newest at index 0
   bit   tx_hist[$];
   bit   rx_hist[$];
   bit   [6:0] m_mask = '0;
   bit   m_inv = 1'b0;
   bit   e_txv = 0, e_txb = 0, e_rxv = 0, e_rxb = 0;

   function automatic bit hist_parity(ref bit h[$], input bit [6:0] mk);
      bit p = 1'b0;
      for (int k = 0; k < 7; k++) if (mk[k] && k < h.size()) p ^= h[k];
      return p;
   endfunction

   always @(posedge clk) begin
      if (rst) begin
         tx_hist = {}; rx_hist = {};
         for (int k = 0; k < 7; k++) begin tx_hist.push_back(1'b0); rx_hist.push_back(1'b0); end
         m_mask = '0; m_inv = 0;
         e_txv = 0; e_txb = 0; e_rxv = 0; e_rxb = 0;
      end else begin
         e_txv = tx_valid_in;
         e_rxv = rx_valid_in;
         if (tx_valid_in) begin
            e_txb = tx_bit_in ^ hist_parity(tx_hist, m_mask);
            tx_hist.push_front(e_txb);
            void'(tx_hist.pop_back());
         end
         if (rx_valid_in) begin
            e_rxb = rx_bit_in ^ hist_parity(rx_hist, m_mask);
            rx_hist.push_front(rx_bit_in);
            void'(rx_hist.pop_back());
         end
         if (cfg_we) begin
            m_mask = cfg_data[6:0];
            m_inv  = cfg_data[7];
         end
      end
   end

   task automatic chk(input string req, input string what, input logic act, input logic exp);
      checks++;
      if (act !== exp) begin
         errors++;
         $display("FAIL %s %s: actual %b expected %b at %0t", req, what, act, exp, $time);
      end
   endtask

   always @(negedge clk) begin
      if (!rst && !done) begin
         chk(cur_req, "tx_valid_out", tx_valid_out, e_txv);
         chk(cur_req, "tx_i_out", tx_i_out, e_txb);
         chk(cur_req, "tx_q_out", tx_q_out, e_txb ^ m_inv);
         chk(cur_req, "rx_valid_out", rx_valid_out, e_rxv);
         chk(cur_req, "rx_bit_out", rx_bit_out, e_rxb);
      end
   end

   task automatic cyc(input bit tv, input bit tb, input bit rv, input bit rb,
                      input bit we, input logic [7:0] cd);
      tx_valid_in = tv; tx_bit_in = tb;
      rx_valid_in = rv; rx_bit_in = rb;
      cfg_we = we; cfg_data = cd;
      @(negedge clk);
   endtask

   task automatic do_reset();
      rst = 1'b1;
      cyc(0, 0, 0, 0, 0, 8'h00);
      cyc(0, 0, 0, 0, 0, 8'h00);
      rst = 1'b0;
   endtask

   bit plain[40];
   bit scr[40];

   initial begin
      @(negedge clk);
      do_reset();
      // R1: reset state
      chk("R1", "tx_valid_out", tx_valid_out, 1'b0);
      chk("R1", "rx_valid_out", rx_valid_out, 1'b0);
      chk("R1", "tx_i_out", tx_i_out, 1'b0);
      chk("R1", "tx_q_out", tx_q_out, 1'b0);
      chk("R1", "rx_bit_out", rx_bit_out, 1'b0);

      // R2: zero mask, both sides pass through
      cur_req = "R2";
      for (int i = 0; i < 12; i++) begin
         bit b = 1'($urandom);
         cyc(1, b, 1, ~b, 0, 8'h00);
         chk("R2", "tx passthrough", tx_i_out, b);
         chk("R2", "rx passthrough", rx_bit_out, ~b);
      end

      // R4: impulse into 1 + x^-4 + x^-7 (mask 1001000)
      do_reset();
      cur_req = "R4";
      cyc(0, 0, 0, 0, 1, 8'h48);
      for (int i = 0; i < 12; i++) begin
         cyc(1, (i == 0), 0, 0, 0, 8'h00);
         // impulse response: y0=1, y4=1, y7=y3^y0=1, y8=y4^y1=1, y11=y7^y4=0
         if (i == 0 || i == 4 || i == 7 || i == 8) chk("R4", "impulse one", tx_i_out, 1'b1);
         if (i == 1 || i == 3 || i == 11) chk("R4", "impulse zero", tx_i_out, 1'b0);
      end

      // R3 / R5 / R8: random masks, random data, random gaps
      for (int r = 0; r < 6; r++) begin
         cur_req = "R3";
         cyc(0, 0, 0, 0, 1, {1'b0, 7'($urandom)});
         for (int i = 0; i < 30; i++) begin
            bit tv = ($urandom % 4) != 0;
            bit rv = ($urandom % 4) != 0;
            cur_req = (!tv || !rv) ? "R8" : ((i % 2) ? "R5" : "R3");
            cyc(tv, 1'($urandom), rv, 1'($urandom), 0, 8'h00);
         end
      end

      // R9: quadrature invert
      cur_req = "R9";
      cyc(0, 0, 0, 0, 1, 8'hC8);
      for (int i = 0; i < 8; i++) begin
         cyc(1, 1'($urandom), 0, 0, 0, 8'h00);
         chk("R9", "q inverted", tx_q_out, ~tx_i_out);
      end
      cyc(0, 0, 0, 0, 1, 8'h48);
      cyc(1, 1, 0, 0, 0, 8'h00);
      chk("R9", "q plain", tx_q_out, tx_i_out);

      // R10: write on the same edge as data bits
      cur_req = "R10";
      for (int i = 0; i < 20; i++)
         cyc(1, 1'($urandom), 1, 1'($urandom), (i % 3) == 0, {1'($urandom), 7'($urandom)});

      // R6: round trip from matching zero states
      do_reset();
      cur_req = "R6";
      cyc(0, 0, 0, 0, 1, 8'h48);
      for (int i = 0; i < 40; i++) plain[i] = 1'($urandom);
      for (int i = 0; i < 40; i++) begin
         cyc(1, plain[i], 0, 0, 0, 8'h00);
         scr[i] = tx_i_out;
      end
      for (int i = 0; i < 40; i++) begin
         cyc(0, 0, 1, scr[i], 0, 8'h00);
         chk("R6", "round trip", rx_bit_out, plain[i]);
      end

      // R7: self synchronisation after a scrambled receive state
      cur_req = "R7";
      for (int i = 0; i < 5; i++) cyc(0, 0, 1, 1'($urandom), 0, 8'h00);
      for (int i = 0; i < 40; i++) begin
         cyc(0, 0, 1, scr[i], 0, 8'h00);
         if (i >= 7) chk("R7", "lock", rx_bit_out, plain[i]);
      end

      cyc(0, 0, 0, 0, 0, 8'h00);
      done = 1'b1;
      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
   end

   initial begin
      #200000;
      if (!done) begin
         done = 1'b1;
         checks++; errors++;
         $display("FAIL watchdog: actual timeout expected completion");
         $display("Simulation finished: %0d checks, %0d errors", checks, errors);
         $finish;
      end
   end
endmodule